// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit connects the integer pipeline of a 32-bit core to a byte-addressed, little-endian data memory that is one word wide. On each request it adds a signed 12-bit displacement to a base value to form the effective address. It turns that address into a word address and a lane number. For a store it drives a byte-enable mask and write data arranged by lane. For a load it issues a read and, one cycle later, picks the addressed byte out of the returned word, or passes the whole word, and widens the result to 32 bits with sign or zero fill.

A word access whose effective address is not a multiple of four raises a misalign flag. When the flag is up, that access neither writes nor reads memory. Byte accesses can never be misaligned.

A two-state machine follows load responses. In `ST_IDLE` no response is due. An accepted load in either state moves the machine to `ST_RESP`, which it holds for as long as loads keep arriving back to back. Any cycle without an accepted load returns it to `ST_IDLE`. The lane, size and fill mode of the load are captured together with the transition, so the response path depends only on these captured values and the memory read data.

Top module: `byte_lane_lsu`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended from bit 11 to 32 bits. `mem_addr` is that address with bits 1:0 forced to zero, and the lane is effective address bits 1:0.
- R2: An aligned word store (`req_store`=1, `req_word`=1) drives `mem_be`=4'b1111 and `mem_wdata`=`st_data`.
- R3: A byte store (`req_word`=0) drives `mem_be` one-hot with bit n set, where n is the lane, and drives `st_data[7:0]` on all four lanes of `mem_wdata`. Only that byte of memory changes.
- R4: A word access whose effective address has nonzero bits 1:0 raises `misalign` in the same cycle and forces `mem_be`=0 and `mem_rd`=0, so memory is left unchanged. Byte accesses never raise `misalign`.
- R5: For a signed byte load (`req_unsigned`=0), `ld_data` in the response cycle holds memory byte n in bits 7:0, and bits 31:8 are copies of bit 7 of that byte. Little-endian order applies: lane 0 is bits 7:0 of the word and lane 3 is bits 31:24.
- R6: For an unsigned byte load (`req_unsigned`=1), bits 31:8 of `ld_data` are zero.
- R7: A word load returns the whole memory word on `ld_data`. `req_unsigned` has no effect on word loads or stores.
- R8: `mem_rd` is high exactly when a load is accepted (valid, not a store, not misaligned). `ld_valid` is high in the cycle after each accepted load and low in every other cycle, including back-to-back loads and misaligned loads.
- R9: After reset `ld_valid` is low. With `req_valid` low, `mem_be` is 0 and `mem_rd` and `misalign` are low.
- R10: After word 0xfffff8f5 is stored at address A, a signed byte load from A+1 returns 0xfffffff8 and an unsigned byte load from A+1 returns 0x000000f8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_unsigned | input | 1 | Byte load fill: 1 = zero, 0 = sign |
| base | input | 32 | Base register value |
| offset | input | 12 | Signed displacement |
| st_data | input | 32 | Store data |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-arranged write data |
| mem_rd | output | 1 | Memory read strobe (data returns next cycle) |
| misalign | output | 1 | Misaligned word access flag |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_rd` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
A response state that stays in `ST_RESP` too long, or fails to leave `ST_IDLE`, shows on `ld_valid` in the first cycle after the load cycle. A stale captured lane or fill mode shows on `ld_data` in that same cycle as the wrong byte or wrong upper bits. The bench therefore loads every lane with the top bit both set and clear, and runs loads back to back with different lanes. Faults in lane decoding on the store side show as a wrong mask at once, or only later as corrupted neighbouring bytes. For that reason, each byte store and each suppressed misaligned store is followed by a whole-word read-back.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12,
    localparam int LANES  = XLEN / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              valid,
    input  logic              is_word,
    input  logic [XLEN-1:0]   base,
    input  logic [IMM_W-1:0]  offset,
    output logic [XLEN-1:0]   word_addr,
    output logic [LANE_W-1:0] lane,
    output logic              misalign
);
    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] eff;

    // displacement widened by copying its top bit
    assign disp      = {{(XLEN-IMM_W){offset[IMM_W-1]}}, offset};
    assign eff       = base + disp;
    assign lane      = eff[LANE_W-1:0];
    assign word_addr = {eff[XLEN-1:LANE_W], {LANE_W{1'b0}}};
    assign misalign  = valid && is_word && (lane != '0);
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
    parameter int XLEN = 32,
    localparam int LANES  = XLEN / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              en,
    input  logic              is_word,
    input  logic [LANE_W-1:0] lane,
    input  logic [XLEN-1:0]   st_data,
    output logic [LANES-1:0]  be,
    output logic [XLEN-1:0]   wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g]          = en && (is_word || (lane == LANE_W'(g)));
        assign wdata[8*g +: 8] = is_word ? st_data[8*g +: 8] : st_data[7:0];
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
    parameter int XLEN = 32,
    localparam int LANES  = XLEN / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              active,
    input  logic              is_word,
    input  logic              uns,
    input  logic [LANE_W-1:0] lane,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   data
);
    logic [7:0] lane_bytes [LANES];
    logic [7:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_bytes[g] = rdata[8*g +: 8];
    end

    assign picked = lane_bytes[lane];

    always_comb begin
        if (!active) begin
            data = '0;
        end else if (is_word) begin
            data = rdata;
        end else if (uns) begin
            data = {{(XLEN-8){1'b0}}, picked};
        end else begin
            data = {{(XLEN-8){picked[7]}}, picked};
        end
    end
endmodule

// File: rtl/byte_lane_lsu.sv
module byte_lane_lsu #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12,
    localparam int LANES  = XLEN / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic             req_word,
    input  logic             req_unsigned,
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] offset,
    input  logic [XLEN-1:0]  st_data,
    output logic [XLEN-1:0]  mem_addr,
    output logic [LANES-1:0] mem_be,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             mem_rd,
    output logic             misalign,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             ld_valid,
    output logic [XLEN-1:0]  ld_data
);
    import lsu_pkg::*;

    resp_state_e       state, state_nx;
    logic [LANE_W-1:0] lane;
    logic              load_go;
    logic              store_go;
    logic [LANE_W-1:0] ctx_lane;
    logic              ctx_word;
    logic              ctx_uns;

    lsu_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addr (
        .valid     (req_valid),
        .is_word   (req_word),
        .base      (base),
        .offset    (offset),
        .word_addr (mem_addr),
        .lane      (lane),
        .misalign  (misalign)
    );

    assign load_go  = req_valid && !req_store && !misalign;
    assign store_go = req_valid &&  req_store && !misalign;

    lsu_store_lanes #(.XLEN(XLEN)) u_store (
        .en      (store_go),
        .is_word (req_word),
        .lane    (lane),
        .st_data (st_data),
        .be      (mem_be),
        .wdata   (mem_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = load_go ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = load_go ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // captured load context, used in the response cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_lane <= '0;
            ctx_word <= 1'b0;
            ctx_uns  <= 1'b0;
        end else if (load_go) begin
            ctx_lane <= lane;
            ctx_word <= req_word;
            ctx_uns  <= req_unsigned;
        end
    end

    // outputs of the machine
    always_comb begin
        mem_rd   = load_go;
        ld_valid = (state == ST_RESP);
    end

    lsu_load_extract #(.XLEN(XLEN)) u_load (
        .active  (ld_valid),
        .is_word (ctx_word),
        .uns     (ctx_uns),
        .lane    (ctx_lane),
        .rdata   (mem_rdata),
        .data    (ld_data)
    );

    // R4: a misaligned access touches no memory
    a_r4_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == '0 && !mem_rd));

    // R4: byte accesses are never flagged
    a_r4_byte_never_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_word) |-> !misalign);

    // R3: a byte store enables exactly one lane
    a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !req_word) |-> ($countones(mem_be) == 1));

    // R2: an aligned word store enables every lane
    a_r2_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_word && !misalign) |-> (&mem_be));

    // R8: a read strobe is answered in the next cycle
    a_r8_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ld_valid);

    // R8: no response without a read strobe
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> !ld_valid);

    // R6: unsigned byte results carry zero upper bits
    a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ctx_uns && !ctx_word) |-> (ld_data[XLEN-1:8] == '0));

    // R5: signed byte results copy bit 7 upward
    a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ctx_uns && !ctx_word) |->
        (ld_data[XLEN-1:8] == {(XLEN-8){ld_data[7]}}));
endmodule

// File: tb/test_byte_lane_lsu.sv
module test_byte_lane_lsu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_word = 1'b0, req_unsigned = 1'b0;
    logic [31:0] base = '0;
    logic [11:0] offset = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;
    logic        mem_rd, misalign, ld_valid;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] ram     [16];
    logic [31:0] ref_mem [16];
    bit          pend_lv = 1'b0;
    logic [31:0] pend_ld = '0;

    always #2 clk = ~clk;

    byte_lane_lsu i_byte_lane_lsu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_word(req_word), .req_unsigned(req_unsigned), .base(base), .offset(offset),
        .st_data(st_data), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .misalign(misalign), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // synchronous memory model driven by the unit
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= ram[mem_addr[5:2]];
        for (int k = 0; k < 4; k++)
            if (mem_be[k]) ram[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // one cycle: compare last response, drive a request, compare request outputs
    task automatic op(bit v, bit st, bit wd, bit un, logic [31:0] b, logic [11:0] off,
                      logic [31:0] sd);
        logic [31:0] ea, w, exp_wd;
        logic [3:0]  exp_be;
        logic [7:0]  by;
        bit          mis, ld_go;
        int          ln;
        @(negedge clk);
        chk("R8 ld_valid", {31'b0, ld_valid}, {31'b0, pend_lv});
        if (pend_lv) chk("R5/R6/R7/R10 ld_data", ld_data, pend_ld);
        req_valid = v; req_store = st; req_word = wd; req_unsigned = un;
        base = b; offset = off; st_data = sd;
        #1;
        ea  = b + {{20{off[11]}}, off};
        ln  = int'(ea[1:0]);
        mis = v && wd && (ea[1:0] != 2'b00);
        ld_go = v && !st && !mis;
        exp_be = 4'b0;
        exp_wd = wd ? sd : {4{sd[7:0]}};
        if (v && st && !mis) exp_be = wd ? 4'hf : (4'b1 << ln);
        chk("R4 misalign", {31'b0, misalign}, {31'b0, mis});
        chk("R2/R3/R4/R9 mem_be", {28'b0, mem_be}, {28'b0, exp_be});
        chk("R8 mem_rd", {31'b0, mem_rd}, {31'b0, ld_go});
        if (v) chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
        if (v && st && !mis) chk("R2/R3 mem_wdata", mem_wdata, exp_wd);
        if (v && st && !mis)
            for (int k = 0; k < 4; k++)
                if (exp_be[k]) ref_mem[ea[5:2]][8*k +: 8] = exp_wd[8*k +: 8];
        w  = ref_mem[ea[5:2]];
        by = w[8*ln +: 8];
        pend_lv = ld_go;
        pend_ld = wd ? w : (un ? {24'h0, by} : {{24{by[7]}}, by});
    endtask

    task automatic idle();
        op(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 12'h0, 32'h0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) begin ram[k] = '0; ref_mem[k] = '0; end
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 ld_valid at reset", {31'b0, ld_valid}, 32'h0);
        chk("R9 mem_be at reset", {28'b0, mem_be}, 32'h0);
        rst_n = 1'b1;
        idle();
        // R10 / R1: word store with negative displacement to address 0x8
        op(1, 1, 1, 0, 32'h10, 12'hff8, 32'hfffff8f5);
        op(1, 0, 0, 0, 32'h8, 12'h001, 32'h0);   // R5/R10 signed byte A+1
        op(1, 0, 0, 1, 32'h8, 12'h001, 32'h0);   // R6/R10 unsigned byte A+1
        op(1, 0, 1, 1, 32'h8, 12'h000, 32'h0);   // R7 word load, unsigned ignored
        idle();
        // R3: byte store into lane 2 of a known word
        op(1, 1, 1, 0, 32'hC, 12'h000, 32'h11223344);
        op(1, 1, 0, 0, 32'hC, 12'h002, 32'h55AA66AB);
        op(1, 0, 1, 0, 32'hC, 12'h000, 32'h0);   // expect 0x11AB3344
        // R4: misaligned word store must leave memory alone
        op(1, 1, 1, 0, 32'h4, 12'h000, 32'hCAFEBABE);
        op(1, 1, 1, 0, 32'h4, 12'h001, 32'h12345678);
        op(1, 0, 1, 0, 32'h4, 12'h000, 32'h0);
        // R4/R8: misaligned word load, no read, no response
        op(1, 0, 1, 0, 32'h4, 12'h003, 32'h0);
        idle();
        // R5/R6: every lane, both fills, back-to-back loads
        op(1, 1, 1, 0, 32'h20, 12'h000, 32'h7F80017E);
        for (int k = 0; k < 4; k++) begin
            op(1, 0, 0, 0, 32'h20, 12'(k), 32'h0);
            op(1, 0, 0, 1, 32'h20, 12'(k), 32'h0);
        end
        // R3: byte stores on every lane, then read back
        for (int k = 0; k < 4; k++)
            op(1, 1, 0, 0, 32'h30, 12'(k), 32'h000000C0 + k);
        op(1, 0, 1, 0, 32'h30, 12'h000, 32'h0);
        // R1: largest positive displacement with a high base
        op(1, 0, 0, 0, 32'h80000000, 12'h7ff, 32'h0);
        // R9: no request means no strobes
        idle();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule